// File: doc/BRIEF.md
# Branch-Interval Cycle Count Compressor

This block measures how many clock cycles pass between one branch event and the next. When a branch strobe arrives, the block takes the running interval count, packs it into a 14-bit floating-point style code and presents that code for one cycle. In the same cycle it restarts its counter at 1, so the next interval is measured from that branch.

Small intervals are stored exactly. Longer intervals keep their eight most significant bits after the leading one, and the lower bits are dropped, so the result is always rounded down. One code value is reserved for a count that went past the counter's range. A separate flag marks records whose interval was not fully observed, either because the interval began at reset or because counting was paused during it. A consumer should treat a flagged count as zero. A combinational decoder, kept in the RTL, turns a code back into an integer so the code can be checked.

Top module: `cyc_interval_compressor`

## Requirements
- R1: The code has the exponent E in bits [13:8] and the mantissa M in bits [7:0]. With E = 0 it stands for M. With E > 0 it stands for (256 + M) shifted left by E − 1.
- R2: Counts from 0 to 255 are encoded exactly, with E = 0 and M equal to the count.
- R3: A count n of 256 or more, with leading one at bit p, is encoded with E = p − 7. M holds the eight bits below the leading one. The decoded value is at most n and differs from n by less than 2^(E−1).
- R4: If the counter has saturated at all ones of its CNT_W width, or the exponent would reach 63, the code is 14'h3FFF.
- R5: rec_valid is high for exactly one cycle, the cycle after each cycle in which branch_stb is high. rec_code and rec_unknown are updated together with that pulse and hold their values otherwise.
- R6: On a branch the counter restarts at 1. A branch in the very next cycle therefore reports a count of 1, and the reported count equals the number of cycles since the previous branch while counting is enabled.
- R7: In non-branch cycles with cnt_en low, the counter does not advance.
- R8: The first record after reset has rec_unknown set.
- R9: rec_unknown is set for a record if cnt_en was low in any cycle of its interval. The interval runs from the previous branch cycle, inclusive, to the current branch cycle, exclusive. Otherwise rec_unknown is clear.
- R10: After reset, rec_valid, rec_code and rec_unknown are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counting enable |
| branch_stb | input | 1 | Branch event strobe |
| rec_valid | output | 1 | One-cycle record pulse |
| rec_code | output | 14 | Compressed interval count |
| rec_unknown | output | 1 | Interval was not fully observed |

## Verification
The assertions check the following on every cycle:
- the pulse timing against the strobe;
- the restart of the counter to 1;
- exact encoding below 256;
- the saturation code;
- the decode bound, which says the decoded value never exceeds the count and falls short by less than one rounding step;
- the unknown flag after a paused cycle.

Only the bench's scenarios show the following:
- the end-to-end interval values for chosen gaps, including the powers of two and their neighbours;
- the first-record flag after reset;
- the clearing of the flag once a clean interval follows;
- the absence of spurious records.

// File: rtl/cic_pkg.sv
// Package: shared widths and constants for the interval compressor.
// Assumes a 14-bit code split as 6-bit exponent over 8-bit mantissa.
package cic_pkg;
    localparam int MANT_W = 8;
    localparam int EXP_W  = 6;
    localparam int CODE_W = MANT_W + EXP_W;
    // Widest decoded value: hidden one, mantissa, and up to 62 shift positions
    localparam int DEC_W  = 1 + MANT_W + (2 ** EXP_W) - 2;
    localparam logic [CODE_W-1:0] OVF_CODE = '1;
endpackage

// File: rtl/cic_counter.sv
// Module: cic_counter
// Running interval counter. It counts enabled cycles, saturates at all ones
// and reloads 1 on a branch. It also tracks whether the current interval
// has seen a paused cycle. Assumes a synchronous active-low reset.
module cic_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             branch_stb,
    output logic [CNT_W-1:0] count_q,
    output logic             stale_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Purpose: advance, hold or restart the interval count and its stale mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            stale_q <= 1'b1;
        end else if (branch_stb) begin
            count_q <= CNT_W'(1);
            stale_q <= !cnt_en;
        end else begin
            if (cnt_en && (count_q != CNT_MAX)) begin
                count_q <= count_q + CNT_W'(1);
            end
            if (!cnt_en) begin
                stale_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cic_encoder.sv
// Module: cic_encoder
// Combinational compressor from a raw count to the 14-bit code.
// It finds the leading one, drops the bits below the 8-bit mantissa (so it
// rounds toward zero) and saturates to the overflow code.
// Assumes CNT_W >= 9.
module cic_encoder
    import cic_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0]  count_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int POS_W = ($clog2(CNT_W) > 6) ? $clog2(CNT_W) : 7;

    logic [POS_W-1:0]  lead_pos;
    logic [POS_W-1:0]  exp_full;
    logic [POS_W-1:0]  shift_amt;
    logic [MANT_W-1:0] mant;
    logic              exp_limit_hit;
    logic              saturated;
    logic              is_small;

    // Purpose: leading-one position, with the highest set bit winning
    always_comb begin
        lead_pos = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (count_i[i]) lead_pos = POS_W'(i);
        end
    end

    assign exp_full  = lead_pos - POS_W'(7);
    assign shift_amt = lead_pos - POS_W'(8);
    assign mant      = MANT_W'(count_i >> shift_amt);
    assign saturated = &count_i;
    assign is_small  = (count_i < CNT_W'(256));

    // Only a wide counter can push the exponent up to the reserved value
    generate
        if (CNT_W - 8 >= 63) begin : g_exp_limit
            assign exp_limit_hit = (exp_full >= POS_W'(63));
        end else begin : g_no_exp_limit
            assign exp_limit_hit = 1'b0;
        end
    endgenerate

    // Purpose: choose between the exact, the normalised and the overflow code
    always_comb begin
        if (saturated || (!is_small && exp_limit_hit)) begin
            code_o = OVF_CODE;
        end else if (is_small) begin
            code_o = {EXP_W'(0), count_i[MANT_W-1:0]};
        end else begin
            code_o = {EXP_W'(exp_full), mant};
        end
    end
endmodule

// File: rtl/cic_decoder.sv
// Module: cic_decoder
// Combinational expansion of a 14-bit code back to an integer, used to check
// the compression. The overflow code is flagged, and its value field is
// not meaningful.
module cic_decoder
    import cic_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DEC_W-1:0]  value_o,
    output logic              is_ovf_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [MANT_W-1:0] mant_f;

    assign exp_f    = code_i[CODE_W-1:MANT_W];
    assign mant_f   = code_i[MANT_W-1:0];
    assign is_ovf_o = (code_i == OVF_CODE);

    // Purpose: exact value for E = 0, otherwise hidden one and left shift
    always_comb begin
        if (exp_f == '0) begin
            value_o = DEC_W'(mant_f);
        end else begin
            value_o = DEC_W'({1'b1, mant_f}) << (exp_f - EXP_W'(1));
        end
    end
endmodule

// File: rtl/cyc_interval_compressor.sv
// Module: cyc_interval_compressor (top)
// Counts the cycles between branch strobes and registers one compressed
// record per strobe, with a valid pulse and an unknown-interval flag.
// Assumes a synchronous active-low reset and CNT_W >= 9.
module cyc_interval_compressor
    import cic_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              branch_stb,
    output logic              rec_valid,
    output logic [CODE_W-1:0] rec_code,
    output logic              rec_unknown
);
    logic [CNT_W-1:0]  count_q;
    logic              stale_q;
    logic [CODE_W-1:0] enc_code;

    cic_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .branch_stb (branch_stb),
        .count_q    (count_q),
        .stale_q    (stale_q)
    );

    cic_encoder #(.CNT_W(CNT_W)) u_encoder (
        .count_i (count_q),
        .code_o  (enc_code)
    );

    // Purpose: capture the record on a strobe and pulse valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid   <= 1'b0;
            rec_code    <= '0;
            rec_unknown <= 1'b0;
        end else begin
            rec_valid <= branch_stb;
            if (branch_stb) begin
                rec_code    <= enc_code;
                rec_unknown <= stale_q;
            end
        end
    end
endmodule

// File: rtl/cic_checker.sv
// Module: cic_checker
// Assertion checker bound into the top. It watches the ports and the
// internal interval count.
module cic_checker
    import cic_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              branch_stb,
    input logic              rec_valid,
    input logic [CODE_W-1:0] rec_code,
    input logic              rec_unknown,
    input logic [CNT_W-1:0]  count_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DEC_W-1:0] dec_val;
    logic             dec_ovf;
    logic [DEC_W-1:0] step_val;

    cic_decoder u_dec (
        .code_i   (rec_code),
        .value_o  (dec_val),
        .is_ovf_o (dec_ovf)
    );

    // Purpose: one rounding step for the exponent of the current code
    always_comb begin
        step_val = DEC_W'(1) << (rec_code[CODE_W-1:MANT_W] - EXP_W'(1));
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rec_valid == ($past(branch_stb) && $past(rst_n))); // R5

    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        branch_stb |=> count_q == CNT_W'(1)); // R6

    AST_SMALL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_stb && count_q < CNT_W'(256)) |=>
            rec_code == {EXP_W'(0), $past(count_q[MANT_W-1:0])}); // R2

    AST_DECODE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_stb && count_q != CNT_MAX && count_q >= CNT_W'(256)) |=>
            (!dec_ovf && dec_val <= DEC_W'($past(count_q)) &&
             (DEC_W'($past(count_q)) - dec_val) < step_val)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_stb && count_q == CNT_MAX) |=> rec_code == OVF_CODE); // R4

    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !branch_stb) |=> $stable(count_q)); // R7

    AST_UNKNOWN_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !branch_stb) ##1 branch_stb |=> rec_unknown); // R9
endmodule

bind cyc_interval_compressor cic_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .branch_stb  (branch_stb),
    .rec_valid   (rec_valid),
    .rec_code    (rec_code),
    .rec_unknown (rec_unknown),
    .count_q     (count_q)
);

// File: tb/tb_cyc_interval_compressor.sv
`timescale 1ns/1ps
module tb_cyc_interval_compressor;
    localparam int W_BIG   = 32;
    localparam int W_SMALL = 10;

    typedef struct {
        logic [13:0]     code;
        logic            unk;
        longint unsigned n;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        branch_stb = 1'b0;
    logic        v_big, u_big, v_sm, u_sm;
    logic [13:0] c_big, c_sm;

    cyc_interval_compressor #(.CNT_W(W_BIG)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .branch_stb(branch_stb),
        .rec_valid(v_big), .rec_code(c_big), .rec_unknown(u_big));

    cyc_interval_compressor #(.CNT_W(W_SMALL)) dut_small (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .branch_stb(branch_stb),
        .rec_valid(v_sm), .rec_code(c_sm), .rec_unknown(u_sm));

    exp_t            q_exp[2][$];
    longint unsigned m_cnt[2];
    bit              m_stale[2];
    int              checks = 0;
    int              fails = 0;
    bit              done = 1'b0;

    function automatic longint unsigned cnt_max(int k);
        return (k == 0) ? ((64'd1 << W_BIG) - 1) : ((64'd1 << W_SMALL) - 1);
    endfunction

    // Reference encoding written from the requirements (shift down until 9 bits)
    function automatic logic [13:0] model_enc(longint unsigned n, int k);
        longint unsigned v;
        int e;
        if (n == cnt_max(k)) return 14'h3FFF;
        if (n < 256) return {6'd0, n[7:0]};
        v = n; e = 0;
        while (v >= 512) begin v = v >> 1; e++; end
        if (e + 1 >= 63) return 14'h3FFF;
        return {6'(e + 1), 8'(v - 256)};
    endfunction

    function automatic longint unsigned model_dec(logic [13:0] c);
        if (c[13:8] == 6'd0) return longint'(c[7:0]);
        return (longint'(256) + longint'(c[7:0])) << (c[13:8] - 1);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: one cycle of stimulus, pushing the expected record on a branch
    task automatic step(bit en, bit br, string tag);
        @(negedge clk);
        cnt_en = en;
        branch_stb = br;
        for (int k = 0; k < 2; k++) begin
            if (br) begin
                q_exp[k].push_back('{model_enc(m_cnt[k], k), m_stale[k], m_cnt[k], tag});
                m_cnt[k] = 1;
                m_stale[k] = !en;
            end else begin
                if (en && m_cnt[k] != cnt_max(k)) m_cnt[k]++;
                if (!en) m_stale[k] = 1'b1;
            end
        end
    endtask

    task automatic gap(int g, string tag);
        repeat (g - 1) step(1'b1, 1'b0, tag);
        step(1'b1, 1'b1, tag);
    endtask

    // Monitor: compare each record against the head of its queue
    task automatic observe(int k, logic v, logic [13:0] c, logic u);
        exp_t e;
        longint unsigned d;
        if (!v) return;
        if (q_exp[k].size() == 0) begin
            check(1'b0, "R5", "unexpected record", 1, 0);
            return;
        end
        e = q_exp[k].pop_front();
        check(c == e.code, e.tag, "code", longint'(c), longint'(e.code));
        check(u == e.unk, e.tag, "unknown flag", longint'(u), longint'(e.unk));
        if (c != 14'h3FFF) begin
            d = model_dec(c);
            // R1 R3: decoded value rounds down by less than one step
            check(d <= e.n, "R1 R3", "decode above count", longint'(d), longint'(e.n));
            if (c[13:8] != 0)
                check((e.n - d) < (longint'(1) << (c[13:8] - 1)), "R3",
                      "rounding error", longint'(e.n - d), 0);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            observe(0, v_big, c_big, u_big);
            observe(1, v_sm, c_sm, u_sm);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_stale[k] = 1'b1; end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(v_big == 0 && c_big == 0 && u_big == 0, "R10", "reset outputs",
              longint'({v_big, c_big, u_big}), 0);
        check(v_sm == 0 && c_sm == 0 && u_sm == 0, "R10", "reset outputs small",
              longint'({v_sm, c_sm, u_sm}), 0);
        rst_n = 1'b1;
        gap(5, "R8");                        // first record flagged
        repeat (3) gap(1, "R6");             // back-to-back report 1
        gap(10, "R2");
        gap(255, "R2");
        gap(256, "R3");
        gap(257, "R3");
        gap(300, "R3");
        gap(511, "R3");
        gap(512, "R3");
        gap(513, "R3");
        gap(1000, "R3");
        gap(1022, "R3");
        gap(1100, "R3 R4");                  // small counter saturates
        gap(5000, "R3 R4");
        gap(70001, "R3 R4");
        // R7 R9: paused cycles are not counted and mark the record
        repeat (5) step(1'b1, 1'b0, "R7");
        repeat (7) step(1'b0, 1'b0, "R7");
        repeat (2) step(1'b1, 1'b0, "R7");
        step(1'b1, 1'b1, "R7 R9");
        gap(4, "R9");                        // clean interval, flag clears
        repeat (2) step(1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, "R9");              // branch cycle with enable low
        gap(3, "R9");
        gap(2, "R1");
        step(1'b1, 1'b0, "R5");
        repeat (4) @(negedge clk);
        check(q_exp[0].size() == 0, "R5", "missing records", q_exp[0].size(), 0);
        check(q_exp[1].size() == 0, "R5", "missing records small", q_exp[1].size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule